// File: doc/BRIEF.md
# Double-Buffered Spike Row Sweeper

This block owns the read side of a pair of spike-bit memories that take turns. At any moment one bank is *present*: it holds the events for the time step now being processed. The other bank is *future*: some other agent is filling it with events for the next step, and this block leaves it alone. Each memory row packs eight axons, one bit per axon, where a 1 means the axon spiked. Axon `a` lives in row `a >> 3` at bit `a & 7`. A 17-bit input count covers up to 131072 axons, which is 16384 rows.

A one-cycle start pulse swaps the two banks, latches the input count and begins a sweep. The block first primes the fixed-latency read pipeline of the present bank with three reads. It then moves the rows, in ascending order, to a downstream consumer, one row per cycle in which the consumer is ready. A clear address trails the read address by the read latency. Each row is therefore written to zero in the same cycle that its data is handed downstream, and the bank is left empty for its next turn as the future bank. When every row has been handed over, a one-cycle done flag is raised and the block goes idle.

The memories sit outside the block. Each bank's read pipeline is enable-gated: a cycle with the read enable high captures the addressed row and shifts the pipeline by one stage. The read data port always shows the row captured `RD_LAT` enabled reads earlier.

Top module: `spike_sweeper`

## Requirements
- R1: While reset is high, and in the first cycle after it, `ready_o`, `done_o` and `mask_vld_o` are 0, `mask_o` is 0, and neither bank sees a read or write enable. The bank select resets to 0, which makes bank 0 present.
- R2: A start pulse accepted in idle toggles the bank select. The first sweep after reset therefore reads bank 1, the next reads bank 0, and so on. The future bank never sees a read or write enable during a sweep.
- R3: After the clock edge that accepts start, exactly three cycles issue reads to the present bank at rows 0, 1 and 2, with `ready_o` low and no writes. `ready_o` is high in the fourth cycle.
- R4: In each cycle with `ready_o` and `cons_rdy_i` high and rows still left, the next row in ascending order (starting at row 0) appears on `mask_o` after that clock edge, with `mask_vld_o` high for exactly that one cycle.
- R5: In a cycle with `ready_o` high and `cons_rdy_i` low, the present bank sees no read or write, and `mask_o` keeps its value while `mask_vld_o` is low.
- R6: After a sweep over N rows, rows 0..N-1 of the present bank hold zero, and every other row of both banks holds its prior value. Only zero is ever written.
- R7: N is the input count divided by 8, rounded up. The count is sampled at the start edge, and later changes to the input have no effect on that sweep.
- R8: An input count of zero finishes the sweep with no valid mask.
- R9: With the consumer always ready, `done_o` is first high N+5 clock edges after the edge that accepts start. It stays high for one cycle, after which `ready_o` and `done_o` are both low.
- R10: A start pulse while a sweep is under way is ignored: the bank select, the row order and the row limit are all unchanged.
- R11: During the sweep phase, the read address stays exactly `RD_LAT` rows ahead of the clear address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Time-step start pulse |
| in_count_i | input | 17 | Number of input axons for the step |
| cons_rdy_i | input | 1 | Consumer ready; advances the sweep by one row |
| mask_o | output | 8 | Spike mask of the row just handed over |
| mask_vld_o | output | 1 | `mask_o` carries a new row this cycle |
| ready_o | output | 1 | Pipeline primed; sweep in progress |
| done_o | output | 1 | One-cycle completion pulse |
| b0_raddr_o | output | 14 | Bank 0 read row |
| b0_ren_o | output | 1 | Bank 0 read enable (advances its read pipeline) |
| b0_rdata_i | input | 8 | Bank 0 read data |
| b0_waddr_o | output | 14 | Bank 0 write row |
| b0_wen_o | output | 1 | Bank 0 write enable |
| b0_wdata_o | output | 8 | Bank 0 write data |
| b1_raddr_o | output | 14 | Bank 1 read row |
| b1_ren_o | output | 1 | Bank 1 read enable (advances its read pipeline) |
| b1_rdata_i | input | 8 | Bank 1 read data |
| b1_waddr_o | output | 14 | Bank 1 write row |
| b1_wen_o | output | 1 | Bank 1 write enable |
| b1_wdata_o | output | 8 | Bank 1 write data |

## Verification
In every advancing cycle of the sweep, the block both issues a read of row r+3 and clears row r in the same bank. The read and the write can therefore collide on one memory in one cycle. The bench provokes this with long runs of consumer-ready, and with random stalls that break those runs at every phase of the pipeline. It judges the result two ways: each handed-over mask must equal the row preloaded into the bank, and after done the swept rows must be zero while every row past the limit, and the whole other bank, is unchanged.

// File: rtl/sweep_pkg.sv
package sweep_pkg;

  typedef enum logic [2:0] {
    ST_RESET  = 3'd0,
    ST_IDLE   = 3'd1,
    ST_FILL   = 3'd2,
    ST_SWEEP  = 3'd3,
    ST_FINISH = 3'd4
  } sweep_state_e;

  localparam int unsigned NUM_BANKS = 2;

endpackage

// File: rtl/sweep_fsm.sv
module sweep_fsm
  import sweep_pkg::*;
#(
  parameter int unsigned CNT_W    = 17,
  parameter int unsigned ROW_BITS = 8,
  parameter int unsigned RD_LAT   = 3,
  localparam int unsigned IDX_W   = $clog2(ROW_BITS),
  localparam int unsigned CTR_W   = CNT_W - IDX_W + 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             start_i,
  input  logic [CNT_W-1:0] count_i,
  input  logic             cons_rdy_i,
  output logic             sel_o,
  output logic [CTR_W-1:0] rd_addr_o,
  output logic [CTR_W-1:0] clr_addr_o,
  output logic             rd_issue_o,
  output logic             clr_issue_o,
  output logic             ready_o,
  output logic             done_o
);

  sweep_state_e state_q, state_d;
  logic             sel_q;
  logic [CTR_W-1:0] rd_q, clr_q, limit_q, limit_d;
  logic             accept, sweep_adv, fill_issue;

  // rows = ceil(count / ROW_BITS)
  assign limit_d = {1'b0, count_i[CNT_W-1:IDX_W]} + CTR_W'(|count_i[IDX_W-1:0]);

  assign accept     = (state_q == ST_IDLE) && start_i;
  assign fill_issue = (state_q == ST_FILL);
  assign sweep_adv  = (state_q == ST_SWEEP) && cons_rdy_i && (clr_q != limit_q);

  always_comb begin
    state_d = state_q;
    case (state_q)
      ST_RESET:  state_d = ST_IDLE;
      ST_IDLE:   if (start_i) state_d = ST_FILL;
      ST_FILL:   if (rd_q == CTR_W'(RD_LAT - 1)) state_d = ST_SWEEP;
      ST_SWEEP:  if (clr_q == limit_q) state_d = ST_FINISH;
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_RESET;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ST_RESET;
      sel_q   <= 1'b0;
      rd_q    <= '0;
      clr_q   <= '0;
      limit_q <= '0;
    end else begin
      state_q <= state_d;
      if (accept) begin
        sel_q   <= ~sel_q;
        limit_q <= limit_d;
        rd_q    <= '0;
        clr_q   <= '0;
      end else if (state_q == ST_RESET) begin
        rd_q  <= '0;
        clr_q <= '0;
      end else begin
        if (fill_issue || sweep_adv) rd_q  <= rd_q + 1'b1;
        if (sweep_adv)               clr_q <= clr_q + 1'b1;
      end
    end
  end

  assign sel_o       = sel_q;
  assign rd_addr_o   = rd_q;
  assign clr_addr_o  = clr_q;
  assign rd_issue_o  = fill_issue || sweep_adv;
  assign clr_issue_o = sweep_adv;
  assign ready_o     = (state_q == ST_SWEEP);
  assign done_o      = (state_q == ST_FINISH);

  AST_CLR_TRAILS_READ: assert property (@(posedge clk) disable iff (rst)
    (state_q == ST_SWEEP) |-> (rd_q == clr_q + CTR_W'(RD_LAT))); // R11
  AST_FILL_BEFORE_READY: assert property (@(posedge clk) disable iff (rst)
    $rose(ready_o) |-> ($past(state_q) == ST_FILL)); // R3
  AST_BUSY_KEEPS_SELECT: assert property (@(posedge clk) disable iff (rst)
    (state_q != ST_IDLE) |=> $stable(sel_q)); // R10
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o); // R9

endmodule

// File: rtl/bank_router.sv
module bank_router
  import sweep_pkg::*;
#(
  parameter int unsigned ADDR_W   = 14,
  parameter int unsigned ROW_BITS = 8,
  localparam int unsigned CTR_W   = ADDR_W + 1
) (
  input  logic                                 clk,
  input  logic                                 rst,
  input  logic                                 sel_i,
  input  logic [CTR_W-1:0]                     rd_addr_i,
  input  logic [CTR_W-1:0]                     clr_addr_i,
  input  logic                                 rd_issue_i,
  input  logic                                 clr_issue_i,
  input  logic [NUM_BANKS-1:0][ROW_BITS-1:0]   rdata_i,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0]     raddr_o,
  output logic [NUM_BANKS-1:0]                 ren_o,
  output logic [NUM_BANKS-1:0][ADDR_W-1:0]     waddr_o,
  output logic [NUM_BANKS-1:0]                 wen_o,
  output logic [NUM_BANKS-1:0][ROW_BITS-1:0]   wdata_o,
  output logic [ROW_BITS-1:0]                  present_rdata_o
);

  for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
    logic is_present;
    assign is_present = (sel_i == 1'(g));
    assign raddr_o[g] = is_present ? rd_addr_i[ADDR_W-1:0]  : '0;
    assign waddr_o[g] = is_present ? clr_addr_i[ADDR_W-1:0] : '0;
    assign ren_o[g]   = rd_issue_i  && is_present;
    assign wen_o[g]   = clr_issue_i && is_present;
    assign wdata_o[g] = '0;
  end

  assign present_rdata_o = rdata_i[sel_i];

  AST_ONE_BANK_ACTIVE: assert property (@(posedge clk) disable iff (rst)
    $onehot0(ren_o | wen_o)); // R2

endmodule

// File: rtl/mask_stage.sv
module mask_stage #(
  parameter int unsigned ROW_BITS = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                adv_i,
  input  logic [ROW_BITS-1:0] rdata_i,
  output logic [ROW_BITS-1:0] mask_o,
  output logic                vld_o
);

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_o <= '0;
      vld_o  <= 1'b0;
    end else begin
      vld_o <= adv_i;
      if (adv_i) mask_o <= rdata_i;
    end
  end

  AST_MASK_HOLDS: assert property (@(posedge clk) disable iff (rst)
    !vld_o |-> $stable(mask_o)); // R5

endmodule

// File: rtl/spike_sweeper.sv
module spike_sweeper
  import sweep_pkg::*;
#(
  parameter int unsigned CNT_W    = 17,
  parameter int unsigned ROW_BITS = 8,
  parameter int unsigned RD_LAT   = 3,
  localparam int unsigned IDX_W   = $clog2(ROW_BITS),
  localparam int unsigned ADDR_W  = CNT_W - IDX_W,
  localparam int unsigned CTR_W   = ADDR_W + 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                start_i,
  input  logic [CNT_W-1:0]    in_count_i,
  input  logic                cons_rdy_i,
  output logic [ROW_BITS-1:0] mask_o,
  output logic                mask_vld_o,
  output logic                ready_o,
  output logic                done_o,
  output logic [ADDR_W-1:0]   b0_raddr_o,
  output logic                b0_ren_o,
  input  logic [ROW_BITS-1:0] b0_rdata_i,
  output logic [ADDR_W-1:0]   b0_waddr_o,
  output logic                b0_wen_o,
  output logic [ROW_BITS-1:0] b0_wdata_o,
  output logic [ADDR_W-1:0]   b1_raddr_o,
  output logic                b1_ren_o,
  input  logic [ROW_BITS-1:0] b1_rdata_i,
  output logic [ADDR_W-1:0]   b1_waddr_o,
  output logic                b1_wen_o,
  output logic [ROW_BITS-1:0] b1_wdata_o
);

  logic             sel, rd_issue, clr_issue;
  logic [CTR_W-1:0] rd_addr, clr_addr;
  logic [NUM_BANKS-1:0][ROW_BITS-1:0] rdata_v, wdata_v;
  logic [NUM_BANKS-1:0][ADDR_W-1:0]   raddr_v, waddr_v;
  logic [NUM_BANKS-1:0]               ren_v, wen_v;
  logic [ROW_BITS-1:0]                present_rdata;

  sweep_fsm #(.CNT_W(CNT_W), .ROW_BITS(ROW_BITS), .RD_LAT(RD_LAT)) u_fsm (
    .clk(clk), .rst(rst), .start_i(start_i), .count_i(in_count_i),
    .cons_rdy_i(cons_rdy_i), .sel_o(sel), .rd_addr_o(rd_addr),
    .clr_addr_o(clr_addr), .rd_issue_o(rd_issue), .clr_issue_o(clr_issue),
    .ready_o(ready_o), .done_o(done_o)
  );

  assign rdata_v[0] = b0_rdata_i;
  assign rdata_v[1] = b1_rdata_i;

  bank_router #(.ADDR_W(ADDR_W), .ROW_BITS(ROW_BITS)) u_router (
    .clk(clk), .rst(rst), .sel_i(sel), .rd_addr_i(rd_addr),
    .clr_addr_i(clr_addr), .rd_issue_i(rd_issue), .clr_issue_i(clr_issue),
    .rdata_i(rdata_v), .raddr_o(raddr_v), .ren_o(ren_v), .waddr_o(waddr_v),
    .wen_o(wen_v), .wdata_o(wdata_v), .present_rdata_o(present_rdata)
  );

  mask_stage #(.ROW_BITS(ROW_BITS)) u_mask (
    .clk(clk), .rst(rst), .adv_i(clr_issue), .rdata_i(present_rdata),
    .mask_o(mask_o), .vld_o(mask_vld_o)
  );

  assign b0_raddr_o = raddr_v[0];
  assign b0_ren_o   = ren_v[0];
  assign b0_waddr_o = waddr_v[0];
  assign b0_wen_o   = wen_v[0];
  assign b0_wdata_o = wdata_v[0];
  assign b1_raddr_o = raddr_v[1];
  assign b1_ren_o   = ren_v[1];
  assign b1_waddr_o = waddr_v[1];
  assign b1_wen_o   = wen_v[1];
  assign b1_wdata_o = wdata_v[1];

  AST_CLEAR_ONLY_READY: assert property (@(posedge clk) disable iff (rst)
    (b0_wen_o || b1_wen_o) |-> ready_o); // R6
  AST_VALID_AFTER_HANDSHAKE: assert property (@(posedge clk) disable iff (rst)
    mask_vld_o |-> $past(ready_o && cons_rdy_i)); // R4
  AST_STALL_NO_ACCESS: assert property (@(posedge clk) disable iff (rst)
    (ready_o && !cons_rdy_i) |-> !(b0_ren_o || b1_ren_o || b0_wen_o || b1_wen_o)); // R5

endmodule

// File: tb/spike_sweeper_bench.sv
module spike_sweeper_bench;
  localparam int LAT = 3;
  localparam int MD  = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic        rst, start_i, cons_rdy_i;
  logic [16:0] in_count_i;
  logic [7:0]  mask_o;
  logic        mask_vld_o, ready_o, done_o;
  logic [13:0] raddr [2];
  logic [13:0] waddr [2];
  logic        ren [2];
  logic        wen [2];
  logic [7:0]  wdata [2];
  logic [7:0]  rdata [2];

  spike_sweeper u_spike_sweeper (
    .clk(clk), .rst(rst), .start_i(start_i), .in_count_i(in_count_i),
    .cons_rdy_i(cons_rdy_i), .mask_o(mask_o), .mask_vld_o(mask_vld_o),
    .ready_o(ready_o), .done_o(done_o),
    .b0_raddr_o(raddr[0]), .b0_ren_o(ren[0]), .b0_rdata_i(rdata[0]),
    .b0_waddr_o(waddr[0]), .b0_wen_o(wen[0]), .b0_wdata_o(wdata[0]),
    .b1_raddr_o(raddr[1]), .b1_ren_o(ren[1]), .b1_rdata_i(rdata[1]),
    .b1_waddr_o(waddr[1]), .b1_wen_o(wen[1]), .b1_wdata_o(wdata[1])
  );

  // Memory model: enable-gated read pipeline of depth LAT per bank
  logic [7:0] mem  [2][MD];
  logic [7:0] pipe [2][LAT];
  int bad_wdata = 0, bad_addr = 0;

  assign rdata[0] = pipe[0][LAT-1];
  assign rdata[1] = pipe[1][LAT-1];

  always @(posedge clk) begin
    for (int b = 0; b < 2; b++) begin
      if (wen[b]) begin
        if (waddr[b] >= MD) bad_addr++;
        else mem[b][waddr[b][5:0]] <= wdata[b];
        if (wdata[b] != 8'd0) bad_wdata++;
      end
      if (ren[b]) begin
        if (raddr[b] >= MD) bad_addr++;
        pipe[b][0] <= mem[b][raddr[b][5:0]];
        for (int k = 1; k < LAT; k++) pipe[b][k] <= pipe[b][k-1];
      end
    end
  end

  int checks = 0, errors = 0;
  int exp_sel = 0;
  bit finished = 0;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int rows_for(input int count);
    return (count + 7) / 8;
  endfunction

  task automatic sweep(input int count, input int stall_pct, input bit mid_start);
    int n, pres, c, row, mism, other_mism;
    bit prev_ready, prev_rdy, seen_done, exp_vld;
    logic [7:0] last_mask;
    logic [7:0] snap [2][MD];
    n = rows_for(count);
    pres = 1 - exp_sel;
    @(negedge clk);
    for (int b = 0; b < 2; b++)
      for (int r = 0; r < MD; r++) begin
        mem[b][r] = 8'($urandom);
        snap[b][r] = mem[b][r];
      end
    start_i = 1'b1;
    in_count_i = 17'(count);
    cons_rdy_i = 1'b1;
    last_mask = mask_o;
    c = 0; row = 0; prev_ready = 0; prev_rdy = 0; seen_done = 0;
    while (!seen_done && c < 3000) begin
      @(posedge clk);
      c++;
      @(negedge clk);
      start_i = (mid_start && c == 5);
      if (c == 1) in_count_i = 17'($urandom % 131072); // R7: ignored after start
      exp_vld = prev_ready && prev_rdy && (row != n);
      chk(mask_vld_o == exp_vld, "R4 valid", mask_vld_o, exp_vld);
      if (mask_vld_o) begin
        chk(row < MD && mask_o == snap[pres][row % MD], "R4 row data", mask_o, snap[pres][row % MD]);
        row++;
        last_mask = mask_o;
      end else begin
        chk(mask_o == last_mask, "R5 mask hold", mask_o, last_mask);
      end
      if (c <= 3) begin
        chk(!ready_o, "R3 ready low in fill", ready_o, 0);
        chk(ren[pres] && !ren[1-pres] && !wen[0] && !wen[1], "R3 fill reads only", ren[pres], 1);
        chk(raddr[pres] == 14'(c - 1), "R3 fill row", raddr[pres], c - 1);
      end
      if (c == 4) chk(ready_o, "R3 ready after fill", ready_o, 1);
      if (ready_o) chk(!ren[1-pres] && !wen[1-pres], "R2 future bank idle", wen[1-pres], 0);
      if (done_o) begin
        seen_done = 1;
        chk(row == n, "R7 row count", row, n);
        if (count == 0) chk(row == 0, "R8 zero count", row, 0);
        if (stall_pct == 0) chk(c == n + 5, "R9 done timing", c, n + 5);
      end
      prev_ready = ready_o;
      cons_rdy_i = (($urandom % 100) >= stall_pct);
      prev_rdy = cons_rdy_i;
      #1;
      if (ready_o && !cons_rdy_i)
        chk(!ren[pres] && !wen[pres], "R5 stall no access", wen[pres], 0);
    end
    chk(seen_done, "R9 done seen", seen_done, 1);
    start_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!done_o && !ready_o, "R9 single pulse then idle", done_o, 0);
    mism = 0; other_mism = 0;
    for (int r = 0; r < MD; r++) begin
      if (mem[pres][r] != ((r < n) ? 8'd0 : snap[pres][r])) mism++;
      if (mem[1-pres][r] != snap[1-pres][r]) other_mism++;
    end
    chk(mism == 0, "R6 present bank cleared rows", mism, 0);
    chk(other_mism == 0, "R6 future bank untouched", other_mism, 0);
    chk(bad_wdata == 0 && bad_addr == 0, "R6 only zero writes in range", bad_wdata + bad_addr, 0);
    exp_sel = pres;
  endtask

  initial begin
    void'($urandom(32'd20240611));
    for (int b = 0; b < 2; b++)
      for (int k = 0; k < LAT; k++) pipe[b][k] = 8'd0;
    rst = 1'b1; start_i = 1'b0; cons_rdy_i = 1'b0; in_count_i = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(!ready_o && !done_o && !mask_vld_o && mask_o == 8'd0, "R1 reset outputs", mask_o, 0);
    chk(!ren[0] && !ren[1] && !wen[0] && !wen[1], "R1 reset no access", wen[0], 0);
    rst = 1'b0;
    @(posedge clk);
    @(negedge clk);
    chk(!ready_o && !done_o && !mask_vld_o, "R1 after reset idle", ready_o, 0);
    // first sweep reads bank 1 (R2), directed corners
    sweep(64, 0, 0);    // R9 exact timing, 8 rows
    sweep(0, 0, 0);     // R8
    sweep(1, 0, 0);     // R7 ceil
    sweep(9, 0, 0);     // R7 partial row
    sweep(17, 30, 1);   // R10 start during sweep
    sweep(300, 0, 0);   // R11 long back-to-back read+clear
    sweep(300, 50, 0);  // R5 heavy stalls
    for (int i = 0; i < 8; i++) sweep($urandom % 320, $urandom % 60, i[0]);
    if (!finished) begin
      finished = 1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++;
      errors++;
      $display("FAIL watchdog expired actual 0 expected 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule